// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the host-facing register file of a PC-style real-time clock. A host reaches 128 byte locations through two addresses. A write to the even address selects a location. An access to the odd address then reads or writes the selected location. Four of the locations are control and status registers, referred to here as A, B, C and D, at indices 10, 11, 12 and 13. The other locations are plain storage.

The block owns the interrupt status register C and the interrupt line. The periodic, alarm and update engines sit elsewhere and send single-cycle strobes to set their flags in C. The block raises the line when a flagged event is enabled in B. A read of C returns its contents and then clears it. The block also enforces the special write rules of A and B, and it exports A and B so that the rest of the clock can follow the selected rates and modes.

Top module: `rtc_regport`

## Requirements
- R1: A write at `addr`=0 loads the index with the low 7 bits of `wdata`. While `addr`=0 and `rd_en`=1, `rdata` is 0xFF.
- R2: With `addr`=1, any index other than 10 to 13 reads back the byte last written to that index.
- R3: Writes to C (index 12) and D (index 13) are ignored. D always reads 0x80.
- R4: A write to A (index 10) stores bits 6:0 from `wdata` and keeps the current value of bit 7 (the update-in-progress flag).
- R5: A write to B (index 11) with bit 7 (freeze) set clears bit 7 of A. The stored B has bit 4 (update-interrupt enable) forced to 0.
- R6: On a write to B, the interrupt flag (C bit 7) and `irq` become 1 if any of C bits 6:4 is set together with the matching enable among bits 6:4 of the new B value. Otherwise they become 0.
- R7: A read of C presents its current value on `rdata`. After that clock edge, C is 0x00 and `irq` is 0.
- R8: After `rst_n` is released, A=0x26, B=0x02, C=0x00, D=0x80 and `irq`=0.
- R9: `dev_rst` clears B bits 6, 5 and 3 and leaves the other bits of B unchanged. It clears C to 0x00 and drops `irq`. It takes priority over any access or strobe in the same cycle.
- R10: `flag_set` bits 2:0 set C bits 6:4 (periodic, alarm, update). A strobed flag whose enable bit in B (bits 6:4, same order) is 1 sets C bit 7 and raises `irq`. `irq` always equals C bit 7.
- R11: A flag strobe that arrives in the same cycle as a read of C is kept in C after the clear, together with the interrupt flag if that event is enabled.
- R12: `uip_set` sets A bit 7 and `uip_clr` clears it. `uip_set` is ignored while B bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| dev_rst | input | 1 | Synchronous device reset of the enables and flags |
| addr | input | 1 | 0 = index port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` and the current state |
| flag_set | input | 3 | Event strobes: bit 2 periodic, bit 1 alarm, bit 0 update |
| uip_set | input | 1 | Set the update-in-progress bit |
| uip_clr | input | 1 | Clear the update-in-progress bit |
| irq | output | 1 | Interrupt level |
| ctrl_a | output | 8 | Current register A |
| ctrl_b | output | 8 | Current register B |

## Verification
The assertions check four invariants on every cycle:
- `irq` is never high without an event flag.
- Freeze mode never coexists with an update-interrupt enable.
- A write to A keeps the update-in-progress bit.
- A device reset or a plain C read leaves the line low.

Only the bench's scenarios can show the values themselves:
- the byte stored at every index;
- the exhaustive combination of enables and strobes;
- the re-evaluation of the line when B is rewritten;
- a strobe that survives a concurrent clearing read.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
    localparam int IDX_A = 10;
    localparam int IDX_B = 11;
    localparam int IDX_C = 12;
    localparam int IDX_D = 13;

    localparam logic [7:0] A_RST = 8'h26;
    localparam logic [7:0] B_RST = 8'h02;
    localparam logic [7:0] D_VAL = 8'h80;

    localparam int BIT_UIP   = 7;
    localparam int BIT_FRZ   = 7;
    localparam int BIT_UEN   = 4;
    localparam int BIT_IRQF  = 7;

    // bits of B cleared by a device reset: periodic, alarm, square-wave enables
    localparam logic [7:0] B_DEVRST_MASK = 8'h68;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] c;
    } ctrl_state_t;
endpackage

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_regport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_rst,
    input  logic       wr_a,
    input  logic       wr_b,
    input  logic       rd_c,
    input  logic [7:0] wdata,
    input  logic [2:0] flag_set,
    input  logic       uip_set,
    input  logic       uip_clr,
    output logic [7:0] reg_a,
    output logic [7:0] reg_b,
    output logic [7:0] reg_c,
    output logic [7:0] reg_d,
    output logic       irq
);
    ctrl_state_t st_d, st_q;

    logic [7:0] b_wr;
    logic [2:0] flags_kept;
    logic       irqf_kept;
    logic [2:0] flags_new;

    always_comb begin
        st_d = st_q;

        // value B would take if written now; freeze suppresses the update enable
        b_wr = wdata;
        if (wdata[BIT_FRZ]) begin
            b_wr[BIT_UEN] = 1'b0;
        end

        // update-in-progress bit
        if (wr_a) begin
            st_d.a = {st_q.a[BIT_UIP], wdata[6:0]};
        end
        if (wr_b && wdata[BIT_FRZ]) begin
            st_d.a[BIT_UIP] = 1'b0;
        end else if (uip_clr) begin
            st_d.a[BIT_UIP] = 1'b0;
        end else if (uip_set && !st_q.b[BIT_FRZ]) begin
            st_d.a[BIT_UIP] = 1'b1;
        end

        if (wr_b) begin
            st_d.b = b_wr;
        end

        // status: clearing read first, then strobes merge in
        flags_kept = rd_c ? 3'b000 : st_q.c[6:4];
        irqf_kept  = rd_c ? 1'b0   : st_q.c[BIT_IRQF];
        flags_new  = flags_kept | flag_set;

        st_d.c = 8'h00;
        st_d.c[6:4] = flags_new;
        if (wr_b) begin
            st_d.c[BIT_IRQF] = |(b_wr[6:4] & flags_new);
        end else begin
            st_d.c[BIT_IRQF] = irqf_kept | (|(st_q.b[6:4] & flag_set));
        end

        if (dev_rst) begin
            st_d.b = st_q.b & ~B_DEVRST_MASK;
            st_d.c = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{a: A_RST, b: B_RST, c: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_a = st_q.a;
    assign reg_b = st_q.b;
    assign reg_c = st_q.c;
    assign reg_d = D_VAL;
    assign irq   = st_q.c[BIT_IRQF];

    // R10: the line is never up without a recorded event
    assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|reg_c[6:4]));

    // R5: freeze mode and update-interrupt enable never both stored
    assert_frz_masks_uen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_b[BIT_FRZ] && reg_b[BIT_UEN]));

    // R4: a write to A alone leaves the update-in-progress bit
    assert_uip_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !wr_b && !uip_set && !uip_clr) |=> (reg_a[BIT_UIP] == $past(reg_a[BIT_UIP])));

    // R7: a clearing read with no new strobe leaves C empty
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && flag_set == 3'b000 && !wr_b) |=> (reg_c == 8'h00 && !irq));

    // R9: device reset drops the line and the three enables
    assert_dev_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (!irq && (reg_b & B_DEVRST_MASK) == 8'h00));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_regport_pkg::*;
#(
    parameter int REG_BYTES = 128,
    localparam int IDX_W = $clog2(REG_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_rst,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [2:0] flag_set,
    input  logic       uip_set,
    input  logic       uip_clr,
    output logic       irq,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b
);
    logic [IDX_W-1:0] idx_d, idx_q;
    logic             sel_a, sel_b, sel_c, sel_d, sel_ctrl;
    logic             data_wr, data_rd;
    logic [7:0]       store_rd, reg_c, reg_d, sel_val;

    assign sel_a    = (idx_q == IDX_W'(IDX_A));
    assign sel_b    = (idx_q == IDX_W'(IDX_B));
    assign sel_c    = (idx_q == IDX_W'(IDX_C));
    assign sel_d    = (idx_q == IDX_W'(IDX_D));
    assign sel_ctrl = sel_a | sel_b | sel_c | sel_d;
    assign data_wr  = wr_en && addr;
    assign data_rd  = rd_en && addr;

    always_comb begin
        idx_d = idx_q;
        if (wr_en && !addr) begin
            idx_d = wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    rtc_byte_store #(.DEPTH(REG_BYTES)) u_store (
        .clk   (clk),
        .we    (data_wr && !sel_ctrl),
        .waddr (idx_q),
        .wdata (wdata),
        .raddr (idx_q),
        .rdata (store_rd)
    );

    rtc_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_rst  (dev_rst),
        .wr_a     (data_wr && sel_a),
        .wr_b     (data_wr && sel_b),
        .rd_c     (data_rd && sel_c),
        .wdata    (wdata),
        .flag_set (flag_set),
        .uip_set  (uip_set),
        .uip_clr  (uip_clr),
        .reg_a    (ctrl_a),
        .reg_b    (ctrl_b),
        .reg_c    (reg_c),
        .reg_d    (reg_d),
        .irq      (irq)
    );

    always_comb begin
        if (sel_a)      sel_val = ctrl_a;
        else if (sel_b) sel_val = ctrl_b;
        else if (sel_c) sel_val = reg_c;
        else if (sel_d) sel_val = reg_d;
        else            sel_val = store_rd;
    end

    assign rdata = addr ? sel_val : 8'hFF;
endmodule

// File: tb/rtc_regport_test.sv
module rtc_regport_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_rst = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] flag_set = 3'b000;
    logic       uip_set = 1'b0;
    logic       uip_clr = 1'b0;
    logic       irq;
    logic [7:0] ctrl_a, ctrl_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    rtc_regport uut (
        .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .flag_set(flag_set), .uip_set(uip_set), .uip_clr(uip_clr),
        .irq(irq), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; flag_set = 3'b000;
        uip_set = 1'b0; uip_clr = 1'b0; dev_rst = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
    endtask

    task automatic wr_reg(input int idx, input logic [7:0] d);
        wr(1'b0, 8'(idx));
        wr(1'b1, d);
    endtask

    // read at the data port: sample before the edge, side effects at the edge
    task automatic rd_reg(input int idx, input logic [7:0] exp, input string req);
        wr(1'b0, 8'(idx));
        addr = 1'b1; rd_en = 1'b1;
        #2;
        check(req, rdata, exp);
        tick();
    endtask

    task automatic strobe(input logic [2:0] f);
        flag_set = f;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset values
        check("R8 irq", {7'd0, irq}, 8'h00);
        rd_reg(10, 8'h26, "R8 A");
        rd_reg(11, 8'h02, "R8 B");
        rd_reg(12, 8'h00, "R8 C");
        rd_reg(13, 8'h80, "R8 D");

        // R1: even-address read returns all ones
        addr = 1'b0; rd_en = 1'b1; #2;
        check("R1 even read", rdata, 8'hFF);
        tick();

        // R2: sweep every plain index; R1: index loads only 7 bits
        for (int i = 0; i < 128; i++) begin
            if (i < 10 || i > 13) begin
                wr(1'b0, 8'(i) | 8'h80);
                wr(1'b1, 8'((i * 37 + 5) & 255));
            end
        end
        for (int i = 0; i < 128; i++) begin
            if (i < 10 || i > 13) begin
                rd_reg(i, 8'((i * 37 + 5) & 255), "R1 R2 store");
            end
        end

        // R3: C and D ignore writes
        wr_reg(12, 8'hFF);
        rd_reg(12, 8'h00, "R3 C");
        wr_reg(13, 8'h00);
        rd_reg(13, 8'h80, "R3 D");

        // R12 and R4: UIP bit behaviour
        uip_set = 1'b1; tick();
        rd_reg(10, 8'hA6, "R12 uip set");
        wr_reg(10, 8'h00);
        rd_reg(10, 8'h80, "R4 keep 1");
        wr_reg(10, 8'h7F);
        rd_reg(10, 8'hFF, "R4 write low bits");
        uip_clr = 1'b1; tick();
        rd_reg(10, 8'h7F, "R12 uip clr");
        wr_reg(10, 8'hFF);
        rd_reg(10, 8'h7F, "R4 keep 0");
        wr_reg(10, 8'h26);

        // R5: freeze write clears UIP and update enable
        uip_set = 1'b1; tick();
        wr_reg(11, 8'h92);
        rd_reg(11, 8'h82, "R5 B stored");
        rd_reg(10, 8'h26, "R5 uip cleared");
        uip_set = 1'b1; tick();
        rd_reg(10, 8'h26, "R12 set ignored in freeze");
        wr_reg(11, 8'h02);

        // R10: exhaustive enables x strobes
        for (int en = 0; en < 8; en++) begin
            for (int f = 1; f < 8; f++) begin
                wr_reg(11, 8'(en << 4) | 8'h02);
                strobe(3'(f));
                check("R10 irq", {7'd0, irq}, {7'd0, |(3'(en) & 3'(f))});
                rd_reg(12, {|(3'(en) & 3'(f)), 3'(f), 4'h0}, "R10 R7 C value");
                check("R7 C cleared irq", {7'd0, irq}, 8'h00);
                rd_reg(12, 8'h00, "R7 C cleared");
            end
        end

        // R6: enabling after the fact raises, disabling lowers
        wr_reg(11, 8'h02);
        strobe(3'b001);
        check("R6 no irq yet", {7'd0, irq}, 8'h00);
        wr_reg(11, 8'h12);
        check("R6 raise on enable", {7'd0, irq}, 8'h01);
        wr_reg(11, 8'h62);
        check("R6 lower on disable", {7'd0, irq}, 8'h00);
        rd_reg(12, 8'h10, "R6 flag kept");

        // R11: strobe during clearing read survives
        wr_reg(11, 8'h52);
        strobe(3'b001);
        wr(1'b0, 8'd12);
        addr = 1'b1; rd_en = 1'b1; flag_set = 3'b100; #2;
        check("R11 read value", rdata, 8'h90);
        tick();
        check("R11 irq kept", {7'd0, irq}, 8'h01);
        rd_reg(12, 8'hC0, "R11 flag kept");

        // R9: device reset, with a strobe in the same cycle
        wr_reg(11, 8'h7E);
        strobe(3'b111);
        check("R9 pre irq", {7'd0, irq}, 8'h01);
        dev_rst = 1'b1; flag_set = 3'b111; tick();
        check("R9 irq", {7'd0, irq}, 8'h00);
        rd_reg(11, 8'h16, "R9 B");
        rd_reg(12, 8'h00, "R9 C");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule